// File: doc/BRIEF.md
# Burst Write Memory Slave

This block is a memory-mapped slave port that takes multi-beat write bursts and stores them in a small word-addressed RAM. A master presents a start address and a beat count together with the first data word; the slave records both on the edge that accepts that word. Every later word lands at the next address, and wraps modulo the RAM depth. The master may drop `write_i` between words to pause a burst without ending it. The address and count inputs carry no meaning after the first beat.

Backpressure comes from an internal pseudo-random stall generator. It is a Galois LFSR that starts from a fixed seed, so the `waitrequest_o` pattern after every reset is the same and a test that fails can be replayed. Two flags report protocol misuse: a burst count of zero, and a begin strobe while a burst is already open. A combinational peek port reads any RAM word so a test can compare the stored contents with a model.

Top module: `burst_wr_slave`

## Requirements
- R1: A word is taken only on a rising edge where `write_i` is 1 and `waitrequest_o` is 0. A cycle with `waitrequest_o` high changes neither the RAM nor the burst position.
- R2: Start address and beat count are captured from the first accepted word of a burst. The values on `addr_i` and `burstcount_i` during later words, pauses and stalls are ignored.
- R3: The k-th accepted word of a burst (k counted from 0) is written to (start address + k) modulo 2^ADDR_W.
- R4: Byte lane i (bits 8i+7..8i) of the addressed word is updated only when `byteenable_i[i]` is 1. The other lanes keep their old value.
- R5: A cycle with `write_i` low inside an open burst pauses it. The next accepted word continues at the following address.
- R6: The block does not rely on `burst_begin_i`. A burst is processed the same way whether the strobe is high only in a cycle that was stalled, or is never asserted.
- R7: A burst closes on the edge that accepts word number `burstcount`. A new burst may present its first word in the very next cycle.
- R8: A first word with `burstcount_i` = 0 is consumed but writes nothing and opens no burst. `count_err_o` is 1 for the one cycle after that edge.
- R9: Reset closes any open burst and clears the beat counter. The first word accepted after reset starts a new burst at the address presented with it.
- R10: `burst_begin_i` high in any cycle while a burst is open sets `seq_err_o` to 1 for the following cycle.
- R11: `waitrequest_o` is 1 while reset is held. After each reset it follows the same LFSR-driven sequence, and that sequence contains both stall and ready cycles.
- R12: `peek_data_o` shows the current RAM word at `peek_addr_i` with no clock delay. It reflects a write in the cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | Word address, used on the first word of a burst |
| burstcount_i | input | CNT_W | Number of words in the burst, used on the first word |
| write_i | input | 1 | Write request for the current word |
| writedata_i | input | DATA_W | Write data |
| byteenable_i | input | DATA_W/8 | Byte-lane enables for the current word |
| burst_begin_i | input | 1 | Begin-of-burst strobe from the master |
| waitrequest_o | output | 1 | Slave stall; the master holds its outputs while high |
| count_err_o | output | 1 | One-cycle flag: burst with a count of zero |
| seq_err_o | output | 1 | One-cycle flag: begin strobe while a burst is open |
| peek_addr_i | input | ADDR_W | Read-back address for the RAM |
| peek_data_o | output | DATA_W | RAM word at `peek_addr_i` |

## Verification
On every cycle the assertions check the handshake rule for RAM writes, that a stall freezes the burst position, and that base and count stay fixed while a burst is open. They also check the address step of each word, that a pause preserves the position, the closing edge, that the beat counter stays in range, and both error flags. Some things only the bench scenarios can show: that the RAM holds the right merged bytes, including wraparound at the top of the address space; back-to-back bursts; a reset in the middle of a burst; bursts sent without the begin strobe; and the repeatable stall pattern. The bench shows these by comparing every RAM word through the peek port with an arithmetic model.

// File: rtl/bws_pkg.sv
package bws_pkg;

  // Classification of the word seen at the handshake in the current cycle.
  typedef enum logic [2:0] {
    BK_NONE   = 3'd0,  // no word taken this cycle
    BK_BADCNT = 3'd1,  // first word carries a zero count
    BK_SINGLE = 3'd2,  // one-word burst, opens and closes at once
    BK_OPEN   = 3'd3,  // first word of a longer burst
    BK_MID    = 3'd4,  // inner word of an open burst
    BK_LAST   = 3'd5   // closing word of an open burst
  } bws_beat_e;

  function automatic logic beat_writes(input bws_beat_e k);
    return (k == BK_SINGLE) || (k == BK_OPEN) || (k == BK_MID) || (k == BK_LAST);
  endfunction

endpackage

// File: rtl/bws_stall_gen.sv
module bws_stall_gen #(
  parameter int unsigned LFSR_W     = 8,
  parameter logic [LFSR_W-1:0] TAPS = 8'hB8,
  parameter logic [LFSR_W-1:0] SEED = 8'h5A,
  parameter int unsigned STALL_BITS = 2,
  parameter bit          STALL_EN   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  output logic stall_o
);

  logic [LFSR_W-1:0] st_q;
  logic [LFSR_W-1:0] st_d;
  logic              stall_q;

  // One Galois step: shift right, fold the taps in when a one drops out.
  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return s[0] ? ((s >> 1) ^ TAPS) : (s >> 1);
  endfunction

  // Stall whenever the low bits of the next state are all zero.
  function automatic logic stall_of(input logic [LFSR_W-1:0] s);
    return s[STALL_BITS-1:0] == '0;
  endfunction

  assign st_d = lfsr_next(st_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= SEED;
      stall_q <= 1'b1;
    end else begin
      st_q    <= st_d;
      stall_q <= stall_of(st_d);
    end
  end

  generate
    if (STALL_EN) begin : g_stall
      assign stall_o = stall_q;
    end else begin : g_nostall
      assign stall_o = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/bws_burst_ctrl.sv
module bws_burst_ctrl
  import bws_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  burstcount_i,
  input  logic              write_i,
  input  logic              waitreq_i,
  input  logic              begin_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic              active_o,
  output logic [CNT_W-1:0]  beat_cnt_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [CNT_W-1:0]  total_o,
  output logic              count_err_o,
  output logic              seq_err_o
);

  logic              accept;
  logic              active_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  total_q;
  logic              cerr_q;
  logic              serr_q;
  bws_beat_e         kind;

  // Target of word k relative to the captured base, wrapping at the top.
  function automatic logic [ADDR_W-1:0] beat_addr(input logic [ADDR_W-1:0] b,
                                                  input logic [CNT_W-1:0]  k);
    return b + ADDR_W'(k);
  endfunction

  // True when word k is the final one of a burst of length n.
  function automatic logic is_last(input logic [CNT_W-1:0] k,
                                   input logic [CNT_W-1:0] n);
    return (k + CNT_W'(1)) == n;
  endfunction

  assign accept = write_i & ~waitreq_i;

  always_comb begin
    kind = BK_NONE;
    if (accept) begin
      if (!active_q) begin
        if (burstcount_i == '0)
          kind = BK_BADCNT;
        else if (burstcount_i == CNT_W'(1))
          kind = BK_SINGLE;
        else
          kind = BK_OPEN;
      end else if (is_last(cnt_q, total_q)) begin
        kind = BK_LAST;
      end else begin
        kind = BK_MID;
      end
    end
  end

  assign we_o    = beat_writes(kind);
  assign waddr_o = active_q ? beat_addr(base_q, cnt_q) : addr_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      base_q   <= '0;
      total_q  <= '0;
      cerr_q   <= 1'b0;
      serr_q   <= 1'b0;
    end else begin
      cerr_q <= (kind == BK_BADCNT);
      serr_q <= begin_i & active_q;
      unique case (kind)
        BK_OPEN: begin
          active_q <= 1'b1;
          base_q   <= addr_i;
          total_q  <= burstcount_i;
          cnt_q    <= CNT_W'(1);
        end
        BK_MID:  cnt_q <= cnt_q + CNT_W'(1);
        BK_LAST: begin
          active_q <= 1'b0;
          cnt_q    <= '0;
        end
        default: ;
      endcase
    end
  end

  assign active_o    = active_q;
  assign beat_cnt_o  = cnt_q;
  assign base_o      = base_q;
  assign total_o     = total_q;
  assign count_err_o = cerr_q;
  assign seq_err_o   = serr_q;

endmodule

// File: rtl/bws_word_ram.sv
module bws_word_ram #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   waddr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [DATA_W/8-1:0] be_i,
  input  logic [ADDR_W-1:0]   raddr_i,
  output logic [DATA_W-1:0]   rdata_o
);

  localparam int unsigned LANES = DATA_W / 8;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  // One byte-wide array per lane, so each lane's enable is a plain write strobe.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we_i && be_i[g])
        lane_mem[waddr_i] <= wdata_i[g*8 +: 8];
    end

    assign rdata_o[g*8 +: 8] = lane_mem[raddr_i];
  end

endmodule

// File: rtl/burst_wr_slave.sv
module burst_wr_slave #(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned CNT_W      = 4,
  parameter int unsigned LFSR_W     = 8,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 8'h5A,
  parameter int unsigned STALL_BITS = 2,
  parameter bit          STALL_EN   = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [CNT_W-1:0]    burstcount_i,
  input  logic                write_i,
  input  logic [DATA_W-1:0]   writedata_i,
  input  logic [DATA_W/8-1:0] byteenable_i,
  input  logic                burst_begin_i,
  output logic                waitrequest_o,
  output logic                count_err_o,
  output logic                seq_err_o,
  input  logic [ADDR_W-1:0]   peek_addr_i,
  output logic [DATA_W-1:0]   peek_data_o
);

  // Internal events, named at the top so the bound checker can see them.
  logic              ctl_we;
  logic [ADDR_W-1:0] ctl_waddr;
  logic              ctl_active;
  logic [CNT_W-1:0]  ctl_beat_cnt;
  logic [ADDR_W-1:0] ctl_base;
  logic [CNT_W-1:0]  ctl_total;

  bws_stall_gen #(
    .LFSR_W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED),
    .STALL_BITS(STALL_BITS), .STALL_EN(STALL_EN)
  ) u_stall (
    .clk(clk), .rst_n(rst_n), .stall_o(waitrequest_o)
  );

  bws_burst_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .addr_i(addr_i), .burstcount_i(burstcount_i),
    .write_i(write_i), .waitreq_i(waitrequest_o), .begin_i(burst_begin_i),
    .we_o(ctl_we), .waddr_o(ctl_waddr), .active_o(ctl_active),
    .beat_cnt_o(ctl_beat_cnt), .base_o(ctl_base), .total_o(ctl_total),
    .count_err_o(count_err_o), .seq_err_o(seq_err_o)
  );

  bws_word_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .we_i(ctl_we), .waddr_i(ctl_waddr), .wdata_i(writedata_i),
    .be_i(byteenable_i), .raddr_i(peek_addr_i), .rdata_o(peek_data_o)
  );

endmodule

// File: rtl/bws_checker.sv
module bws_checker #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              write_i,
  input logic              waitrequest_o,
  input logic [CNT_W-1:0]  burstcount_i,
  input logic              burst_begin_i,
  input logic              count_err_o,
  input logic              seq_err_o,
  input logic              we,
  input logic [ADDR_W-1:0] waddr,
  input logic              active,
  input logic [CNT_W-1:0]  beat_cnt,
  input logic [ADDR_W-1:0] base,
  input logic [CNT_W-1:0]  total
);

  logic closing;
  assign closing = we && active && ((beat_cnt + CNT_W'(1)) == total);

  assert_we_needs_handshake_R1: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (write_i && !waitrequest_o));

  assert_stall_freezes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    waitrequest_o |=> ($stable(beat_cnt) && $stable(active)));

  assert_base_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !closing) |=> (active && $stable(base) && $stable(total)));

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && active) |-> (waddr == base + ADDR_W'(beat_cnt)));

  assert_pause_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !write_i) |=> (active && $stable(beat_cnt)));

  assert_close_on_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    closing |=> (!active && beat_cnt == '0));

  assert_zero_count_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (write_i && !waitrequest_o && !active && burstcount_i == '0) |=> count_err_o);

  assert_zero_count_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && burstcount_i == '0) |-> !we);

  assert_counter_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (beat_cnt != '0 && beat_cnt < total));

  assert_begin_in_burst_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_begin_i && active) |=> seq_err_o);

endmodule

bind burst_wr_slave bws_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .write_i(write_i), .waitrequest_o(waitrequest_o),
  .burstcount_i(burstcount_i), .burst_begin_i(burst_begin_i),
  .count_err_o(count_err_o), .seq_err_o(seq_err_o),
  .we(ctl_we), .waddr(ctl_waddr), .active(ctl_active),
  .beat_cnt(ctl_beat_cnt), .base(ctl_base), .total(ctl_total)
);

// File: tb/burst_wr_slave_tb_top.sv
module burst_wr_slave_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 6;
  localparam int DW    = 32;
  localparam int CW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int WIN   = 48;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [CW-1:0] burstcount_i = '0;
  logic          write_i = 1'b0;
  logic [DW-1:0] writedata_i = '0;
  logic [3:0]    byteenable_i = '0;
  logic          burst_begin_i = 1'b0;
  logic          waitrequest_o;
  logic          count_err_o;
  logic          seq_err_o;
  logic [AW-1:0] peek_addr_i = '0;
  logic [DW-1:0] peek_data_o;

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] model [DEPTH];
  logic [WIN-1:0] wr_seq_a, wr_seq_b;
  logic [WIN-1:0] cur_seq;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_wr_slave dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .burstcount_i(burstcount_i),
    .write_i(write_i), .writedata_i(writedata_i), .byteenable_i(byteenable_i),
    .burst_begin_i(burst_begin_i), .waitrequest_o(waitrequest_o),
    .count_err_o(count_err_o), .seq_err_o(seq_err_o),
    .peek_addr_i(peek_addr_i), .peek_data_o(peek_data_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Bytes with an enable take new data, the rest keep the model's old word.
  task automatic model_write(input int a, input logic [DW-1:0] d, input logic [3:0] be);
    for (int i = 0; i < 4; i++)
      if (be[i]) model[a % DEPTH][i*8 +: 8] = d[i*8 +: 8];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; write_i = 1'b0; burst_begin_i = 1'b0;
    @(negedge clk);
    check("R11 stall during reset", 64'(waitrequest_o), 64'd1);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      cur_seq[i] = waitrequest_o;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    write_i = 1'b0; burst_begin_i = 1'b0;
  endtask

  // Present one word and return at the negedge before its accepting edge.
  task automatic beat(input logic [AW-1:0] a, input logic [CW-1:0] c,
                      input logic [DW-1:0] d, input logic [3:0] be, input bit beg);
    @(negedge clk);
    addr_i = a; burstcount_i = c; writedata_i = d; byteenable_i = be;
    write_i = 1'b1; burst_begin_i = beg;
    while (waitrequest_o) begin
      @(negedge clk);
      burst_begin_i = 1'b0;
    end
  endtask

  task automatic pause_cycle();
    @(negedge clk);
    write_i = 1'b0; burst_begin_i = 1'b0;
    addr_i = 6'($urandom); burstcount_i = 4'($urandom);
  endtask

  task automatic do_burst(input int b, input int n, input int pause_pct,
                          input bit rand_be, input bit beg_on);
    for (int k = 0; k < n; k++) begin
      logic [DW-1:0] d;
      logic [3:0]    be;
      if (k > 0 && int'($urandom % 100) < pause_pct) pause_cycle();
      d  = $urandom;
      be = rand_be ? 4'($urandom) : 4'hF;
      if (k == 0) beat(AW'(b), CW'(n), d, be, beg_on);
      else        beat(6'($urandom), 4'($urandom), d, be, 1'b0);
      model_write(b + k, d, be);
    end
  endtask

  task automatic compare_all(input string req);
    for (int i = 0; i < DEPTH; i++) begin
      peek_addr_i = AW'(i);
      #1;
      check(req, 64'(peek_data_o), 64'(model[i]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    int hi, lo;
    do_reset();
    wr_seq_a = cur_seq;
    check("R9 count_err after reset", 64'(count_err_o), 64'd0);
    check("R10 seq_err after reset", 64'(seq_err_o), 64'd0);
    hi = 0; lo = 0;
    for (int i = 0; i < WIN; i++) if (wr_seq_a[i]) hi++; else lo++;
    check("R11 stalls present", 64'(hi > 0), 64'd1);
    check("R11 ready present", 64'(lo > 0), 64'd1);

    // Fill the RAM with full-word bursts, no pauses.
    for (int j = 0; j < 8; j++) do_burst(j * 8, 8, 0, 1'b0, 1'b1);
    idle(); idle();
    compare_all("R3 R12 fill");

    // Random lengths, bases, byte enables and pauses.
    for (int j = 0; j < 40; j++) begin
      do_burst(int'($urandom % DEPTH), 1 + int'($urandom % 15), 30, 1'b1, 1'b1);
      idle();
      if (int'($urandom % 3) == 0) idle();
    end
    idle();
    compare_all("R1 R2 R4 R5 random bursts");

    // Wrap past the top of the address space.
    do_burst(60, 10, 20, 1'b0, 1'b1);
    idle();
    compare_all("R3 wrap");

    // Back-to-back bursts, including single words, no idle between them.
    do_burst(5, 3, 0, 1'b0, 1'b1);
    do_burst(30, 1, 0, 1'b0, 1'b1);
    do_burst(31, 4, 0, 1'b1, 1'b1);
    do_burst(2, 1, 0, 1'b0, 1'b1);
    idle();
    compare_all("R7 back to back");

    // No begin strobe at all.
    do_burst(17, 6, 25, 1'b1, 1'b0);
    idle();
    compare_all("R6 no begin strobe");

    // Zero count: word consumed, flagged, nothing stored.
    beat(6'd9, 4'd0, 32'hDEAD_BEEF, 4'hF, 1'b1);
    idle();
    check("R8 count_err pulse", 64'(count_err_o), 64'd1);
    idle();
    check("R8 count_err clears", 64'(count_err_o), 64'd0);
    compare_all("R8 no write");
    do_burst(9, 2, 0, 1'b0, 1'b1);
    idle();
    compare_all("R8 next burst normal");

    // Begin strobe raised during a pause of an open burst.
    begin
      logic [DW-1:0] d;
      d = $urandom;
      beat(6'd40, 4'd3, d, 4'hF, 1'b1);
      model_write(40, d, 4'hF);
      @(negedge clk);
      write_i = 1'b0; burst_begin_i = 1'b1;
      @(negedge clk);
      burst_begin_i = 1'b0;
      check("R10 seq_err pulse", 64'(seq_err_o), 64'd1);
      for (int k = 1; k < 3; k++) begin
        d = $urandom;
        beat(6'($urandom), 4'($urandom), d, 4'hF, 1'b0);
        model_write(40 + k, d, 4'hF);
      end
      idle();
      check("R10 seq_err clears", 64'(seq_err_o), 64'd0);
      compare_all("R10 burst completes");
    end

    // Reset in the middle of a burst, then a fresh burst elsewhere.
    begin
      logic [DW-1:0] d;
      for (int k = 0; k < 2; k++) begin
        d = $urandom;
        beat(k == 0 ? 6'd20 : 6'($urandom), k == 0 ? 4'd5 : 4'($urandom), d, 4'hF, k == 0);
        model_write(20 + k, d, 4'hF);
      end
      do_reset();
      wr_seq_b = cur_seq;
      check("R11 stall sequence repeats", 64'(wr_seq_b), 64'(wr_seq_a));
      do_burst(50, 3, 0, 1'b0, 1'b1);
      idle();
      compare_all("R9 reset mid burst");
    end

    // Peek follows a write in the next cycle.
    beat(6'd33, 4'd1, 32'h1234_5678, 4'hF, 1'b1);
    model_write(33, 32'h1234_5678, 4'hF);
    @(negedge clk);
    write_i = 1'b0;
    peek_addr_i = 6'd33;
    #1;
    check("R12 peek latency", 64'(peek_data_o), 64'h1234_5678);

    report();
  end

endmodule